// File: doc/BRIEF.md
# Four-Way Set-Associative Cache Line Array

This block is the storage and lookup core of a 1 KB write-back cache. It holds 16 sets of 4 ways. Each line keeps a valid flag, a dirty flag, a 26-bit tag and a 128-bit block of four 32-bit words. A controller outside the block splits the address and presents tag, set index and word offset together with read and write enables. The array answers in the same cycle with a hit flag and the addressed word.

In that same compare cycle the array also names the way a miss would fill. It picks the lowest-numbered invalid way in the set. When all four ways are valid, it takes the way index supplied by a separate replacement unit. The array reports whether that victim is dirty and drives its block on the eviction output, so the controller can decide on write-back without waiting a cycle. A refill strobe then loads the memory block into the victim way. On a write request the CPU word is merged into the block and the line is marked dirty.

Top module: `sa4_cache_array`

## Requirements
- R1: Way w of set idx_i hits only when its valid flag is 1 and its stored 26-bit tag equals tag_i. hit_o is the OR of the four way hits and is combinational.
- R2: While rd_en_i is 1 and hit_o is 1, rdata_o carries word off_i (bits off_i*32 +: 32) of the hitting way's block in the same cycle. Otherwise rdata_o is 0.
- R3: When wr_en_i and hit_o are 1 and fill_i is 0 at a rising clock edge, wdata_i replaces word off_i of the hitting line and that line's dirty flag becomes 1. The line's other words stay unchanged.
- R4: victim_way_o is the lowest-numbered way of set idx_i whose valid flag is 0. When all four ways are valid, it equals repl_way_i.
- R5: victim_dirty_o is 1 exactly when the victim way is valid and dirty. evict_blk_o carries that way's whole 128-bit block while victim_dirty_o is 1, and is 0 otherwise. Both are combinational.
- R6: fill_i with hit_o 0 at a clock edge loads fill_blk_i and tag_i into the victim way and sets its valid flag. Its dirty flag becomes wr_req_i (0 means read, 1 means write). For a write, wdata_i is merged at word off_i.
- R7: fill_i while hit_o is 1 changes nothing. wr_en_i while hit_o is 0 and fill_i is 0 changes nothing.
- R8: An active-low asynchronous reset clears every valid and dirty flag. After reset every lookup misses, victim_way_o is 0 and victim_dirty_o is 0.
- R9: A refill or a write changes exactly one way. Every other way of every set keeps its contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tag_i | input | 26 | Request tag |
| idx_i | input | 4 | Set index |
| off_i | input | 2 | Word offset within the block |
| wr_req_i | input | 1 | Request kind: 0 read, 1 write; sets the dirty flag of a refill |
| rd_en_i | input | 1 | Read enable for rdata_o |
| wr_en_i | input | 1 | Write-hit enable |
| fill_i | input | 1 | Refill strobe |
| fill_blk_i | input | 128 | Block from memory for a refill |
| wdata_i | input | 32 | CPU write word |
| repl_way_i | input | 2 | Victim way from the replacement unit |
| hit_o | output | 1 | Tag match in any way |
| rdata_o | output | 32 | Word returned on a read hit |
| victim_way_o | output | 2 | Way a refill would target |
| victim_dirty_o | output | 1 | Victim line is valid and dirty |
| evict_blk_o | output | 128 | Block of a dirty victim, for write-back |

## Verification
hit_o, rdata_o, victim_way_o, victim_dirty_o and evict_blk_o depend only on the inputs and the stored state, so they are due in the same cycle as the request. The bench drives each request after a falling edge and samples these outputs 1 ns later, before the next rising edge. Writes and refills take effect at the rising edge where they are presented. Their results are checked by lookups driven after the following falling edge. After each write or refill the bench sweeps every word of every valid way in the set against its own model.

// File: rtl/sa4_cache_pkg.sv
package sa4_cache_pkg;
  typedef enum logic {
    OP_READ  = 1'b0,
    OP_WRITE = 1'b1
  } req_op_e;
endpackage

// File: rtl/sa4_way_store.sv
module sa4_way_store #(
  parameter int unsigned NUM_SETS = 16,
  parameter int unsigned TAG_W    = 26,
  parameter int unsigned WORD_W   = 32,
  parameter int unsigned WORDS    = 4,
  localparam int unsigned IDX_W   = $clog2(NUM_SETS),
  localparam int unsigned OFF_W   = $clog2(WORDS),
  localparam int unsigned BLK_W   = WORD_W * WORDS
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [IDX_W-1:0]  idx_i,
  input  logic [OFF_W-1:0]  off_i,
  input  logic [TAG_W-1:0]  tag_i,
  input  logic [WORD_W-1:0] wdata_i,
  input  logic [BLK_W-1:0]  fill_blk_i,
  input  logic              fill_dirty_i,
  input  logic              fill_we_i,
  input  logic              word_we_i,
  output logic              valid_o,
  output logic              dirty_o,
  output logic [TAG_W-1:0]  tag_o,
  output logic [BLK_W-1:0]  blk_o
);
  logic [NUM_SETS-1:0] valid_q, dirty_q;
  logic [TAG_W-1:0]    tag_q [NUM_SETS];
  logic [BLK_W-1:0]    blk_q [NUM_SETS];
  logic [BLK_W-1:0]    new_blk;
  logic                merge;

  assign valid_o = valid_q[idx_i];
  assign dirty_o = dirty_q[idx_i];
  assign tag_o   = tag_q[idx_i];
  assign blk_o   = blk_q[idx_i];

  // a write refill merges the CPU word just like a write hit
  assign merge = word_we_i | (fill_we_i & fill_dirty_i);

  always_comb begin
    new_blk = fill_we_i ? fill_blk_i : blk_q[idx_i];
    if (merge) new_blk[off_i*WORD_W +: WORD_W] = wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= '0;
      dirty_q <= '0;
    end else if (fill_we_i) begin
      valid_q[idx_i] <= 1'b1;
      dirty_q[idx_i] <= fill_dirty_i;
    end else if (word_we_i) begin
      dirty_q[idx_i] <= 1'b1;
    end
  end

  // payload needs no reset: qualified by valid_q
  always_ff @(posedge clk_i) begin
    if (fill_we_i) tag_q[idx_i] <= tag_i;
    if (fill_we_i || word_we_i) blk_q[idx_i] <= new_blk;
  end
endmodule

// File: rtl/sa4_tag_match.sv
module sa4_tag_match #(
  parameter int unsigned NUM_WAYS = 4,
  parameter int unsigned TAG_W    = 26,
  localparam int unsigned WAY_W   = $clog2(NUM_WAYS)
) (
  input  logic [NUM_WAYS-1:0] valid_i,
  input  logic [TAG_W-1:0]    tag_i,
  input  logic [TAG_W-1:0]    way_tag_i [NUM_WAYS],
  output logic [NUM_WAYS-1:0] hit_vec_o,
  output logic                hit_o,
  output logic [WAY_W-1:0]    hit_way_o
);
  for (genvar w = 0; w < NUM_WAYS; w++) begin : g_cmp
    assign hit_vec_o[w] = valid_i[w] && (way_tag_i[w] == tag_i);
  end

  assign hit_o = |hit_vec_o;

  always_comb begin
    hit_way_o = '0;
    for (int w = 0; w < NUM_WAYS; w++)
      if (hit_vec_o[w]) hit_way_o = WAY_W'(w);
  end
endmodule

// File: rtl/sa4_victim_pick.sv
module sa4_victim_pick #(
  parameter int unsigned NUM_WAYS = 4,
  localparam int unsigned WAY_W   = $clog2(NUM_WAYS)
) (
  input  logic [NUM_WAYS-1:0] valid_i,
  input  logic [NUM_WAYS-1:0] dirty_i,
  input  logic [WAY_W-1:0]    repl_way_i,
  output logic [WAY_W-1:0]    victim_way_o,
  output logic                victim_dirty_o
);
  logic [WAY_W-1:0] first_free;
  logic             any_free;

  // scan downward so the lowest invalid way wins
  always_comb begin
    first_free = '0;
    any_free   = 1'b0;
    for (int w = NUM_WAYS - 1; w >= 0; w--) begin
      if (!valid_i[w]) begin
        first_free = WAY_W'(w);
        any_free   = 1'b1;
      end
    end
  end

  assign victim_way_o   = any_free ? first_free : repl_way_i;
  assign victim_dirty_o = valid_i[victim_way_o] & dirty_i[victim_way_o];
endmodule

// File: rtl/sa4_cache_array.sv
module sa4_cache_array #(
  parameter int unsigned NUM_SETS = 16,
  parameter int unsigned NUM_WAYS = 4,
  parameter int unsigned TAG_W    = 26,
  parameter int unsigned WORD_W   = 32,
  parameter int unsigned WORDS    = 4,
  localparam int unsigned IDX_W   = $clog2(NUM_SETS),
  localparam int unsigned OFF_W   = $clog2(WORDS),
  localparam int unsigned WAY_W   = $clog2(NUM_WAYS),
  localparam int unsigned BLK_W   = WORD_W * WORDS
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [TAG_W-1:0]  tag_i,
  input  logic [IDX_W-1:0]  idx_i,
  input  logic [OFF_W-1:0]  off_i,
  input  logic              wr_req_i,
  input  logic              rd_en_i,
  input  logic              wr_en_i,
  input  logic              fill_i,
  input  logic [BLK_W-1:0]  fill_blk_i,
  input  logic [WORD_W-1:0] wdata_i,
  input  logic [WAY_W-1:0]  repl_way_i,
  output logic              hit_o,
  output logic [WORD_W-1:0] rdata_o,
  output logic [WAY_W-1:0]  victim_way_o,
  output logic              victim_dirty_o,
  output logic [BLK_W-1:0]  evict_blk_o
);
  import sa4_cache_pkg::*;

  logic [NUM_WAYS-1:0] way_valid, way_dirty, way_hit;
  logic [NUM_WAYS-1:0] fill_we, word_we;
  logic [TAG_W-1:0]    way_tag [NUM_WAYS];
  logic [BLK_W-1:0]    way_blk [NUM_WAYS];
  logic [WAY_W-1:0]    hit_way;
  logic [BLK_W-1:0]    hit_blk;
  logic                fill_dirty;
  logic                do_fill, do_write;

  assign fill_dirty = (req_op_e'(wr_req_i) == OP_WRITE);
  // a refill is only honoured on a miss; it outranks a word write
  assign do_fill  = fill_i & ~hit_o;
  assign do_write = wr_en_i & hit_o & ~fill_i;

  for (genvar w = 0; w < NUM_WAYS; w++) begin : g_way
    assign fill_we[w] = do_fill & (victim_way_o == WAY_W'(w));
    assign word_we[w] = do_write & way_hit[w];

    sa4_way_store #(
      .NUM_SETS(NUM_SETS),
      .TAG_W   (TAG_W),
      .WORD_W  (WORD_W),
      .WORDS   (WORDS)
    ) u_store (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .idx_i       (idx_i),
      .off_i       (off_i),
      .tag_i       (tag_i),
      .wdata_i     (wdata_i),
      .fill_blk_i  (fill_blk_i),
      .fill_dirty_i(fill_dirty),
      .fill_we_i   (fill_we[w]),
      .word_we_i   (word_we[w]),
      .valid_o     (way_valid[w]),
      .dirty_o     (way_dirty[w]),
      .tag_o       (way_tag[w]),
      .blk_o       (way_blk[w])
    );
  end

  sa4_tag_match #(
    .NUM_WAYS(NUM_WAYS),
    .TAG_W   (TAG_W)
  ) u_match (
    .valid_i  (way_valid),
    .tag_i    (tag_i),
    .way_tag_i(way_tag),
    .hit_vec_o(way_hit),
    .hit_o    (hit_o),
    .hit_way_o(hit_way)
  );

  sa4_victim_pick #(
    .NUM_WAYS(NUM_WAYS)
  ) u_victim (
    .valid_i       (way_valid),
    .dirty_i       (way_dirty),
    .repl_way_i    (repl_way_i),
    .victim_way_o  (victim_way_o),
    .victim_dirty_o(victim_dirty_o)
  );

  assign hit_blk     = way_blk[hit_way];
  assign rdata_o     = (rd_en_i && hit_o) ? hit_blk[off_i*WORD_W +: WORD_W] : '0;
  assign evict_blk_o = victim_dirty_o ? way_blk[victim_way_o] : '0;
endmodule

// File: rtl/sa4_cache_array_chk.sv
module sa4_cache_array_chk #(
  parameter int unsigned NUM_WAYS = 4,
  parameter int unsigned TAG_W    = 26,
  parameter int unsigned IDX_W    = 4,
  parameter int unsigned WORD_W   = 32
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic [TAG_W-1:0]    tag_i,
  input logic [IDX_W-1:0]    idx_i,
  input logic                fill_i,
  input logic                wr_en_i,
  input logic                hit_o,
  input logic [WORD_W-1:0]   rdata_o,
  input logic                victim_dirty_o,
  input logic [NUM_WAYS-1:0] way_hit,
  input logic [NUM_WAYS-1:0] way_valid
);
  // no request tag may match two ways of one set
  assert_single_way_hit_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(way_hit));

  assert_miss_reads_zero_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !hit_o |-> rdata_o == '0);

  // while a free way exists it is the victim, and free ways are never dirty
  assert_free_victim_clean_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(&way_valid) |-> !victim_dirty_o);

  assert_fill_then_hit_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fill_i && !hit_o) |=> (!($stable(tag_i) && $stable(idx_i)) || hit_o));

  // a word write on a miss allocates nothing
  assert_write_miss_no_alloc_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && !fill_i && !hit_o) |=> (!($stable(tag_i) && $stable(idx_i)) || !hit_o));
endmodule

bind sa4_cache_array sa4_cache_array_chk #(
  .NUM_WAYS(NUM_WAYS),
  .TAG_W   (TAG_W),
  .IDX_W   (IDX_W),
  .WORD_W  (WORD_W)
) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .tag_i         (tag_i),
  .idx_i         (idx_i),
  .fill_i        (fill_i),
  .wr_en_i       (wr_en_i),
  .hit_o         (hit_o),
  .rdata_o       (rdata_o),
  .victim_dirty_o(victim_dirty_o),
  .way_hit       (way_hit),
  .way_valid     (way_valid)
);

// File: tb/sa4_cache_array_tb.sv
`timescale 1ns/1ps
module sa4_cache_array_tb;
  localparam int SETS = 16;
  localparam int WAYS = 4;

  logic         clk_i = 1'b0;
  logic         rst_ni = 1'b0;
  logic [25:0]  tag_i = '0;
  logic [3:0]   idx_i = '0;
  logic [1:0]   off_i = '0;
  logic         wr_req_i = 1'b0, rd_en_i = 1'b0, wr_en_i = 1'b0, fill_i = 1'b0;
  logic [127:0] fill_blk_i = '0;
  logic [31:0]  wdata_i = '0;
  logic [1:0]   repl_way_i = '0;
  logic         hit_o, victim_dirty_o;
  logic [31:0]  rdata_o;
  logic [1:0]   victim_way_o;
  logic [127:0] evict_blk_o;

  sa4_cache_array u_dut (.*);

  always #2 clk_i = ~clk_i;

  int n_tests = 0, n_fail = 0;
  bit done = 0;

  logic         mv [SETS][WAYS];
  logic         md [SETS][WAYS];
  logic [25:0]  mt [SETS][WAYS];
  logic [127:0] mb [SETS][WAYS];

  task automatic chk(string req, logic [127:0] act, logic [127:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [25:0] mk_tag(int s, int w, int gen);
    return {gen[7:0], s[3:0], w[1:0], 12'hABC};
  endfunction

  function automatic logic [127:0] mk_blk(int seed);
    logic [127:0] b;
    for (int k = 0; k < 4; k++) b[k*32 +: 32] = (seed * 4 + k) ^ 32'h5A00_0000;
    return b;
  endfunction

  function automatic int m_hit_way(int s, logic [25:0] t);
    for (int w = 0; w < WAYS; w++) if (mv[s][w] && mt[s][w] == t) return w;
    return -1;
  endfunction

  function automatic int m_victim(int s, logic [1:0] r);
    for (int w = 0; w < WAYS; w++) if (!mv[s][w]) return w;
    return int'(r);
  endfunction

  function automatic void m_clear();
    for (int s = 0; s < SETS; s++)
      for (int w = 0; w < WAYS; w++) begin mv[s][w] = 0; md[s][w] = 0; end
  endfunction

  // Combinational outputs against the model; inputs already driven.
  task automatic check_outputs(string req);
    int s, hw, vw;
    logic vd;
    s  = int'(idx_i);
    hw = m_hit_way(s, tag_i);
    vw = m_victim(s, repl_way_i);
    vd = mv[s][vw] && md[s][vw];
    chk({req, " R1 hit"}, 128'(hit_o), 128'(hw >= 0));
    chk({req, " R2 rdata"}, 128'(rdata_o),
        (rd_en_i && hw >= 0) ? 128'(mb[s][hw][int'(off_i)*32 +: 32]) : 128'd0);
    chk({req, " R4 victim"}, 128'(victim_way_o), 128'(vw));
    chk({req, " R5 dirty"}, 128'(victim_dirty_o), 128'(vd));
    chk({req, " R5 evict"}, evict_blk_o, vd ? mb[s][vw] : 128'd0);
  endtask

  task automatic lookup(logic [25:0] t, int s, int o, logic [1:0] r, string req);
    @(negedge clk_i);
    tag_i = t; idx_i = 4'(s); off_i = 2'(o); repl_way_i = r;
    rd_en_i = 1; wr_en_i = 0; fill_i = 0;
    #1 check_outputs(req);
  endtask

  // One clocked operation; model updated from the pre-edge state.
  task automatic op(logic [25:0] t, int s, int o, logic [1:0] r, logic f, logic we,
                    logic wreq, logic [31:0] wd, logic [127:0] fb);
    int hw, vw;
    @(negedge clk_i);
    tag_i = t; idx_i = 4'(s); off_i = 2'(o); repl_way_i = r;
    rd_en_i = 0; fill_i = f; wr_en_i = we; wr_req_i = wreq; wdata_i = wd; fill_blk_i = fb;
    hw = m_hit_way(s, t);
    vw = m_victim(s, r);
    @(posedge clk_i);
    if (f && hw < 0) begin
      mb[s][vw] = fb;
      if (wreq) mb[s][vw][o*32 +: 32] = wd;
      mv[s][vw] = 1; md[s][vw] = wreq; mt[s][vw] = t;
    end else if (we && !f && hw >= 0) begin
      mb[s][hw][o*32 +: 32] = wd;
      md[s][hw] = 1;
    end
    #1 fill_i = 0; wr_en_i = 0;
  endtask

  task automatic verify_set(int s, string req);
    for (int w = 0; w < WAYS; w++)
      if (mv[s][w])
        for (int k = 0; k < 4; k++) lookup(mt[s][w], s, k, 2'd0, req);
  endtask

  task automatic reset_check(string req);
    for (int s = 0; s < SETS; s++) begin
      lookup(mk_tag(s, 0, 1), s, 0, 2'(s), req);
      chk({req, " R8 miss"}, 128'(hit_o), 128'd0);
      chk({req, " R8 victim0"}, 128'(victim_way_o), 128'd0);
    end
  endtask

  initial begin
    for (int c = 0; c < 150000; c++) @(posedge clk_i);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    m_clear();
    repeat (3) @(posedge clk_i);
    #1 rst_ni = 1;
    reset_check("R8 after reset");

    // fill every way of every set; R4 lowest invalid wins over repl_way_i
    for (int s = 0; s < SETS; s++)
      for (int w = 0; w < WAYS; w++) begin
        lookup(mk_tag(s, w, 1), s, 0, 2'(3 - w), "R4 free way");
        chk("R4 lowest invalid", 128'(victim_way_o), 128'(w));
        op(mk_tag(s, w, 1), s, w, 2'(3 - w), 1, 0, w[0], 32'hD000_0000 | s * 16 + w,
           mk_blk(s * 8 + w));
        verify_set(s, "R6 R9 refill");
      end

    // write hits, one word of way 2 in each set
    for (int s = 0; s < SETS; s++) begin
      op(mk_tag(s, 2, 1), s, s % 4, 2'd0, 0, 1, 1, 32'hBEEF_0000 + s, '0);
      verify_set(s, "R3 R9 write hit");
    end

    // full sets: external victim, dirty and clean eviction
    for (int s = 0; s < SETS; s++) begin
      lookup(mk_tag(s, 0, 2), s, 0, 2'(s % 4), "R4 R5 full set");
      op(mk_tag(s, 0, 2), s, 1, 2'(s % 4), 1, 0, s[2], 32'hCAFE_0000 + s, mk_blk(500 + s));
      verify_set(s, "R6 R9 eviction refill");
      lookup(mk_tag(s, 0, 2), s, 3, 2'((s + 1) % 4), "R5 after refill");
    end

    // ignored operations
    for (int s = 0; s < SETS; s += 3) begin
      op(mk_tag(s, 1, 1), s, 0, 2'(s % 4), 1, 0, 1, 32'h1111_1111, mk_blk(900 + s));
      verify_set(s, "R7 fill on hit");
      op(mk_tag(s, 3, 7), s, 2, 2'(s % 4), 0, 1, 1, 32'h2222_2222, '0);
      verify_set(s, "R7 write miss");
      lookup(mk_tag(s, 3, 7), s, 2, 2'(s % 4), "R7 write miss no alloc");
    end

    // asynchronous reset mid-run
    @(negedge clk_i);
    rst_ni = 0;
    m_clear();
    #1 rst_ni = 1;
    reset_check("R8 mid-run reset");

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule